// File: doc/BRIEF.md
# Split Decade Counter with Presets

This block is a four-bit counter built from two sections that advance on their own count strobes. A one-bit section drives QA. A three-bit section counts modulo five and drives QB, QC and QD. Everything runs on a single system clock. Each strobe is synchronised into that clock, and its section advances when a high-to-low transition of the strobe is detected.

A mode input selects how the two sections are chained inside the block:
- In BCD mode, count pulses arrive on strobe A, and the falling edge of QA advances the quinary section. The outputs then count a plain 0 to 9 decade.
- In bi-quinary mode, count pulses arrive on strobe B, and the falling edge of QD advances the binary section. QA then becomes a symmetric divide-by-ten square wave.

There are two gated presets:
- A zero preset, enabled only when both of its enables are high.
- A nine preset, enabled only when both of its enables are high. It loads binary 1001 and is useful for nine's-complement work.

Top module: `split_decade_ctr`

## Requirements
- R1: The binary section inverts QA (q_out[0]) once for each detected falling edge of its count source. The update lands within SYNC_STAGES+1 system clock edges of the falling strobe.
- R2: The quinary section steps (QD,QC,QB) = (q_out[3],q_out[2],q_out[1]) through 000, 001, 010, 011, 100 and back to 000. It never holds a value above 100.
- R3: With chain_mode = 0 (BCD), each pulse on strobe_a advances q_out through 0,1,...,9 and back to 0. Pulses on strobe_b leave q_out unchanged.
- R4: With chain_mode = 1 (bi-quinary), each pulse on strobe_b advances q_out through 0,2,4,6,8,1,3,5,7,9 and back to 0. Pulses on strobe_a leave q_out unchanged.
- R5: In bi-quinary mode, QA is high after exactly 5 of every 10 consecutive count pulses.
- R6: When zero_en0 and zero_en1 are both high, q_out becomes 0000 on the next system clock edge. Either enable alone has no effect.
- R7: When nine_en0 and nine_en1 are both high, q_out becomes 1001 on the next system clock edge. Either enable alone has no effect.
- R8: When both presets are requested at once, the nine preset wins.
- R9: While a preset is requested, count strobes do not advance the counter. After the request is released, the counter holds the preset value.
- R10: An active-low rst_n clears q_out to 0000 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| strobe_a | input | 1 | Count strobe of the binary section (BCD mode input) |
| strobe_b | input | 1 | Count strobe of the quinary section (bi-quinary mode input) |
| chain_mode | input | 1 | 0 = BCD chaining, 1 = bi-quinary chaining |
| zero_en0 | input | 1 | First enable of the zero preset |
| zero_en1 | input | 1 | Second enable of the zero preset |
| nine_en0 | input | 1 | First enable of the nine preset |
| nine_en1 | input | 1 | Second enable of the nine preset |
| q_out | output | 4 | Count value {QD,QC,QB,QA} |

## Verification
The bench builds the block with SYNC_STAGES = 3 instead of the default 2. Its pulse widths are derived from that depth, so a deeper synchroniser is exercised while the edge detector still fires exactly once per strobe. Both chaining modes run a full ten-pulse cycle each, which reaches every quinary state and the wrap from 100 to 000 on both chaining paths. Directed steps cover each preset under a single enable, both presets at once, and a preset held while strobes arrive.

// File: rtl/split_decade_pkg.sv
package split_decade_pkg;
   typedef enum logic {
      CHAIN_BCD = 1'b0,
      CHAIN_BIQ = 1'b1
   } chain_e;

   localparam int unsigned CNT_W = 4;
   localparam int unsigned QUIN_W = CNT_W - 1;
   localparam logic [CNT_W-1:0] PRESET_NINE = 4'b1001;
   localparam logic [CNT_W-1:0] PRESET_ZERO = '0;
   localparam logic [QUIN_W-1:0] QUIN_LAST = 3'b100;
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic fall
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 1 || STAGES > 4) begin : g_bad_depth
         $error("strobe_fall_det: STAGES must lie in 1..4");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= strobe;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], strobe};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign fall = last_q & ~sync_q[STAGES-1];

   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);  // R1
endmodule

// File: rtl/div2_stage.sv
module div2_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic load_en,
   input  logic load_val,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (load_en) q <= load_val;
      else if (adv)     q <= ~q;
   end

   AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load_en) |=> (q != $past(q)));  // R1
   AST_DIV2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load_en) |=> $stable(q));  // R9
endmodule

// File: rtl/div5_stage.sv
module div5_stage
   import split_decade_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load_en,
   input  logic [QUIN_W-1:0] load_val,
   output logic [QUIN_W-1:0] q
);
   function automatic logic [QUIN_W-1:0] step(input logic [QUIN_W-1:0] cur);
      logic [QUIN_W-1:0] nxt;
      if (cur == QUIN_LAST || cur == 3'b111) nxt = '0;
      else if (cur[QUIN_W-1])                nxt = 3'b010;
      else                                   nxt = cur + 3'd1;
      return nxt;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (load_en) q <= load_val;
      else if (adv)     q <= step(q);
   end

   AST_QUIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      q <= QUIN_LAST);  // R2
   AST_QUIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load_en && q == QUIN_LAST) |=> (q == '0));  // R2
   AST_QUIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load_en) |=> $stable(q));  // R9
endmodule

// File: rtl/split_decade_ctr.sv
module split_decade_ctr
   import split_decade_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_a,
   input  logic             strobe_b,
   input  logic             chain_mode,
   input  logic             zero_en0,
   input  logic             zero_en1,
   input  logic             nine_en0,
   input  logic             nine_en1,
   output logic [CNT_W-1:0] q_out
);
   logic              fall_a, fall_b;
   logic              nine_hit, zero_hit, load_en;
   logic [CNT_W-1:0]  load_val;
   logic              qa;
   logic [QUIN_W-1:0] qdcb;
   logic              carry_a, carry_b, adv_a, adv_b;
   chain_e            mode;

   strobe_fall_det #(.STAGES(SYNC_STAGES)) i_det_a (
      .clk(clk), .rst_n(rst_n), .strobe(strobe_a), .fall(fall_a));
   strobe_fall_det #(.STAGES(SYNC_STAGES)) i_det_b (
      .clk(clk), .rst_n(rst_n), .strobe(strobe_b), .fall(fall_b));

   assign nine_hit = nine_en0 & nine_en1;
   assign zero_hit = zero_en0 & zero_en1 & ~nine_hit;
   assign load_en  = nine_hit | zero_hit;
   assign load_val = nine_hit ? PRESET_NINE : PRESET_ZERO;

   assign mode    = chain_e'(chain_mode);
   assign carry_a = fall_a & qa;
   assign carry_b = fall_b & (qdcb == QUIN_LAST);
   assign adv_a   = (mode == CHAIN_BIQ) ? carry_b : fall_a;
   assign adv_b   = (mode == CHAIN_BIQ) ? fall_b  : carry_a;

   div2_stage i_bin (
      .clk(clk), .rst_n(rst_n), .adv(adv_a), .load_en(load_en),
      .load_val(load_val[0]), .q(qa));

   div5_stage i_quin (
      .clk(clk), .rst_n(rst_n), .adv(adv_b), .load_en(load_en),
      .load_val(load_val[CNT_W-1:1]), .q(qdcb));

   assign q_out = {qdcb, qa};

   AST_NINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (nine_en0 && nine_en1) |=> (q_out == 4'b1001));  // R7
   AST_NINE_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (nine_en0 && nine_en1 && zero_en0 && zero_en1) |=> (q_out == 4'b1001));  // R8
   AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_en0 && zero_en1 && !(nine_en0 && nine_en1)) |=> (q_out == 4'b0000));  // R6
   AST_BELOW_TEN: assert property (@(posedge clk) disable iff (!rst_n)
      q_out <= 4'd9);  // R3
   AST_BCD_IGNORE_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_mode && !fall_a && !load_en) |=> $stable(q_out));  // R3
   AST_BIQ_IGNORE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_mode && !fall_b && !load_en) |=> $stable(q_out));  // R4
endmodule

// File: tb/test_split_decade_ctr.sv
module test_split_decade_ctr;
   localparam int SYNC = 3;
   localparam logic [4:0] VEC [20] = '{
      5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09, 5'h00,
      5'h12, 5'h14, 5'h16, 5'h18, 5'h11, 5'h13, 5'h15, 5'h17, 5'h19, 5'h10};

   logic clk = 1'b0;
   logic rst_n, strobe_a, strobe_b, chain_mode;
   logic zero_en0, zero_en1, nine_en0, nine_en1;
   logic [3:0] q_out;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   split_decade_ctr #(.SYNC_STAGES(SYNC)) i_split_decade_ctr (
      .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
      .chain_mode(chain_mode), .zero_en0(zero_en0), .zero_en1(zero_en1),
      .nine_en0(nine_en0), .nine_en1(nine_en1), .q_out(q_out));

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_a;
      strobe_a = 1'b1; wait_cyc(SYNC + 2);
      strobe_a = 1'b0; wait_cyc(SYNC + 3);
   endtask

   task automatic pulse_b;
      strobe_b = 1'b1; wait_cyc(SYNC + 2);
      strobe_b = 1'b0; wait_cyc(SYNC + 3);
   endtask

   task automatic do_zero;
      zero_en0 = 1'b1; zero_en1 = 1'b1; wait_cyc(1);
      zero_en0 = 1'b0; zero_en1 = 1'b0; wait_cyc(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int qa_high;
      rst_n = 1'b0; strobe_a = 1'b0; strobe_b = 1'b0; chain_mode = 1'b0;
      zero_en0 = 1'b0; zero_en1 = 1'b0; nine_en0 = 1'b0; nine_en1 = 1'b0;
      wait_cyc(3);
      chk("R10 reset state", q_out, 4'd0);
      rst_n = 1'b1;
      wait_cyc(2);

      qa_high = 0;
      for (int i = 0; i < 20; i++) begin
         if (i == 0 || i == 10) begin
            chain_mode = VEC[i][4];
            do_zero;
         end
         if (VEC[i][4]) pulse_b;
         else           pulse_a;
         chk(VEC[i][4] ? "R4 (R2 quinary order)" : "R3 (R1 binary toggle)",
             q_out, VEC[i][3:0]);
         if (i >= 10 && q_out[0]) qa_high++;
      end
      chk("R5 QA high count", 4'(qa_high), 4'd5);

      // R3: strobe_b ignored in BCD mode
      chain_mode = 1'b0; do_zero;
      pulse_a;
      pulse_b;
      chk("R3 strobe_b ignored", q_out, 4'd1);
      // R4: strobe_a ignored in bi-quinary mode
      chain_mode = 1'b1;
      pulse_a;
      chk("R4 strobe_a ignored", q_out, 4'd1);
      pulse_b;
      chk("R4 step from 1", q_out, 4'd3);

      // R6: a single zero enable does nothing, both clear
      zero_en0 = 1'b1; wait_cyc(2); zero_en0 = 1'b0; wait_cyc(1);
      chk("R6 single zero enable", q_out, 4'd3);
      do_zero;
      chk("R6 zero preset", q_out, 4'd0);

      // R7: a single nine enable does nothing, both load nine
      nine_en1 = 1'b1; wait_cyc(2); nine_en1 = 1'b0; wait_cyc(1);
      chk("R7 single nine enable", q_out, 4'd0);
      nine_en0 = 1'b1; nine_en1 = 1'b1; wait_cyc(1);
      chk("R7 nine preset", q_out, 4'd9);
      nine_en0 = 1'b0; nine_en1 = 1'b0; wait_cyc(1);

      // R8: nine beats zero
      do_zero;
      zero_en0 = 1'b1; zero_en1 = 1'b1; nine_en0 = 1'b1; nine_en1 = 1'b1;
      wait_cyc(1);
      chk("R8 nine priority", q_out, 4'd9);

      // R9: held presets block counting
      zero_en0 = 1'b0; zero_en1 = 1'b0;
      chain_mode = 1'b0;
      pulse_a; pulse_a;
      chk("R9 counting blocked by nine", q_out, 4'd9);
      nine_en0 = 1'b0; nine_en1 = 1'b0; wait_cyc(3);
      chk("R9 holds after release", q_out, 4'd9);
      zero_en0 = 1'b1; zero_en1 = 1'b1;
      pulse_a;
      chk("R9 counting blocked by zero", q_out, 4'd0);
      zero_en0 = 1'b0; zero_en1 = 1'b0; wait_cyc(1);
      pulse_a;
      chk("R1 count resumes", q_out, 4'd1);

      // R10: asynchronous system reset
      pulse_a; pulse_a;
      chk("R3 before reset", q_out, 4'd3);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R10 async reset", q_out, 4'd0);
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule